// File: doc/BRIEF.md
# I2C Slave Mailbox Port

This block is an I2C slave control port. An external host uses it to send bytes to an internal processor core and to collect outbound messages that the core has left for it. Both bus lines are open-drain pairs: a sampled input and a drive-low enable. The port oversamples SCL and SDA with the system clock. It recognises Start, repeated Start and Stop conditions and keeps a bus-busy flag. It acknowledges only its own 7-bit address.

On a write transfer, every received byte is offered to the core through a valid/ready pair. On a read transfer, the port sends the bytes of the oldest queued message, most significant byte first. The core queues messages through a load strobe into a four-entry mailbox. If the core cannot yet accept a byte, or the mailbox has nothing to send, the port holds SCL low and the host waits.

An active-low, open-drain interrupt line is pulled low while any message is queued. It is released once the host has taken the last queued message.

Top module: `i2c_mbox_port`

## Requirements
- R1: A falling SDA while SCL is high (after synchronisation) is a Start; `bus_busy` goes high after a Start and the port begins collecting an address byte, MSB first, with the R/W bit in bit 0 (1 = read).
- R2: A rising SDA while SCL is high is a Stop; only a Stop clears `bus_busy`, and a repeated Start leaves it high.
- R3: When the 7 address bits equal `own_addr`, the port pulls SDA low during the ninth (acknowledge) clock.
- R4: On an address mismatch, the port drives nothing and delivers nothing until the next Start or Stop.
- R5: On a write transfer, each received byte appears on `wr_data` (MSB received first) with `wr_valid` high, and it stays stable until `wr_ready`; the byte is then acknowledged.
- R6: While a received byte waits for `wr_ready`, the port holds SCL low (`scl_oe` = 1).
- R7: On a read transfer, the port sends the oldest message. Byte 0 is bits [15:8] of the loaded word and byte 1 is bits [7:0]. Each byte goes out MSB first, and a host ACK continues into the next byte or the next message.
- R8: If a read needs a byte while the mailbox is empty, the port holds SCL low until a message is loaded.
- R9: `irq_pull` (1 = interrupt line driven low) is high whenever at least one message is queued. It drops only after the host has consumed the last one.
- R10: A message is consumed when its last byte is ACKed or NACKed. A NACK on an earlier byte leaves the message queued, and the next read starts again at byte 0.
- R11: The mailbox holds four messages and `mb_full` is high while it holds four. A load while full is dropped and sets the sticky `mb_overflow`.
- R12: A repeated Start in the middle of a byte discards the partial byte and returns the port to address reception.
- R13: A host NACK on a read byte ends the transfer: the port releases SDA and waits for a Start or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| scl_oe | output | 1 | 1 = hold SCL low (clock stretch) |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 = pull SDA low |
| own_addr | input | 7 | Slave address to match |
| wr_valid | output | 1 | Received byte available for the core |
| wr_data | output | 8 | Received byte |
| wr_ready | input | 1 | Core accepts the byte this cycle |
| mb_load | input | 1 | Queue `mb_msg` into the mailbox |
| mb_msg | input | 16 | Outbound message, two bytes |
| mb_full | output | 1 | Mailbox holds four messages |
| mb_overflow | output | 1 | Sticky: a load was dropped while full |
| irq_pull | output | 1 | 1 = drive the active-low interrupt line low |
| bus_busy | output | 1 | Bus held between Start and Stop |

## Verification
The port is tried with its own address and with a foreign one, and with write transfers under an always-ready core, a stalled core and a randomly hesitating core. These cases separate a correct acknowledge from an address decode that always matches, and a real stretch from a dropped byte. Read transfers cover a whole message, a NACK before the last byte, ACKs that run across two messages, and a read from an empty mailbox. Together they show whether a message is consumed at the right point and whether the interrupt releases only after the last pop. A repeated Start inside a write byte checks that the partial byte is discarded while `bus_busy` stays set. Random rounds then load one to three random messages, write random bytes and drain the mailbox.

// File: rtl/i2c_mbox_pkg.sv
`timescale 1ns/1ps
package i2c_mbox_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_WR_WAIT,
        ST_RD_WAIT,
        ST_HOLD,
        ST_TX,
        ST_RACK,
        ST_IGNORE
    } port_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] hdr,
                                      input logic [ADDR_W-1:0] own);
        return hdr[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
module i2c_bus_cond
    import i2c_mbox_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     busy
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_q;
    logic sda_q;
    logic scl_s;
    logic sda_s;

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.sda   = sda_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (evt.start) begin
            busy <= 1'b1;
        end else if (evt.stop) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_msg_fifo.sv
`timescale 1ns/1ps
module i2c_msg_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] level;
    logic do_push;
    logic do_pop;

    assign empty   = (level == '0);
    assign full    = (level == CNT_W'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push && full) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
    import i2c_mbox_pkg::*;
#(
    parameter int MSG_BYTES = 2,
    parameter int MSG_W     = MSG_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [MSG_W-1:0]  head_msg,
    input  logic              mb_empty,
    output logic              mb_pop,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    input  logic              wr_ready
);
    localparam int IDX_W = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_BYTES - 1);

    port_state_e       state;
    port_state_e       hold_nxt;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        cnt;
    logic [IDX_W-1:0]  idx;
    logic              rw;
    logic              ack_addr;
    logic              host_ack;
    logic [BYTE_W-1:0] sel_byte;
    logic [MSG_W-1:0]  shifted;
    logic              last_byte;

    always_comb begin
        shifted  = head_msg >> ((MSG_BYTES - 1 - int'(idx)) * BYTE_W);
        sel_byte = shifted[BYTE_W-1:0];
    end

    assign last_byte = (idx == LAST_IDX);
    assign mb_pop    = (state == ST_RACK) && evt.fall && last_byte;
    assign wr_valid  = (state == ST_WR_WAIT);
    assign wr_data   = shreg;
    assign scl_oe    = (state == ST_WR_WAIT) || (state == ST_RD_WAIT) ||
                       (state == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            hold_nxt <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            idx      <= '0;
            rw       <= 1'b0;
            ack_addr <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            idx    <= '0;
        end else if (evt.start) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            idx      <= '0;
            ack_addr <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX: begin
                    if (evt.rise) begin
                        shreg <= {shreg[BYTE_W-2:0], evt.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (evt.fall && cnt == 4'd8) begin
                        if (state == ST_RX) begin
                            state <= ST_WR_WAIT;
                        end else if (addr_hit(shreg, own_addr)) begin
                            state    <= ST_ACK;
                            sda_oe   <= 1'b1;
                            ack_addr <= 1'b1;
                            rw       <= shreg[0];
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_WR_WAIT: begin
                    if (wr_ready) begin
                        sda_oe   <= 1'b1;
                        state    <= ST_HOLD;
                        hold_nxt <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (evt.fall) begin
                        sda_oe   <= 1'b0;
                        cnt      <= '0;
                        ack_addr <= 1'b0;
                        state    <= (ack_addr && rw) ? ST_RD_WAIT : ST_RX;
                    end
                end
                ST_RD_WAIT: begin
                    if (!mb_empty) begin
                        shreg    <= sel_byte;
                        sda_oe   <= ~sel_byte[BYTE_W-1];
                        cnt      <= '0;
                        state    <= ST_HOLD;
                        hold_nxt <= ST_TX;
                    end
                end
                ST_HOLD: begin
                    state <= hold_nxt;
                end
                ST_TX: begin
                    if (evt.fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            cnt    <= cnt + 1'b1;
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.rise) begin
                        host_ack <= ~evt.sda;
                    end else if (evt.fall) begin
                        if (last_byte || !host_ack) begin
                            idx <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                        state <= host_ack ? ST_RD_WAIT : ST_IGNORE;
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_mbox_port.sv
`timescale 1ns/1ps
module i2c_mbox_port
    import i2c_mbox_pkg::*;
#(
    parameter int MSG_BYTES  = 2,
    parameter int MBOX_DEPTH = 4,
    parameter int MSG_W      = MSG_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    input  logic              wr_ready,
    input  logic              mb_load,
    input  logic [MSG_W-1:0]  mb_msg,
    output logic              mb_full,
    output logic              mb_overflow,
    output logic              irq_pull,
    output logic              bus_busy
);
    bus_evt_t         evt;
    logic             evt_start;
    logic             evt_stop;
    logic [MSG_W-1:0] head_msg;
    logic             mb_empty;
    logic             mb_pop;

    assign evt_start = evt.start;
    assign evt_stop  = evt.stop;
    assign irq_pull  = ~mb_empty;

    i2c_bus_cond #(.SYNC_STAGES(2)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt),
        .busy  (bus_busy)
    );

    i2c_msg_fifo #(.DEPTH(MBOX_DEPTH), .WIDTH(MSG_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (mb_load),
        .push_data (mb_msg),
        .pop       (mb_pop),
        .head      (head_msg),
        .empty     (mb_empty),
        .full      (mb_full),
        .overflow  (mb_overflow)
    );

    i2c_slave_fsm #(.MSG_BYTES(MSG_BYTES), .MSG_W(MSG_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .own_addr (own_addr),
        .head_msg (head_msg),
        .mb_empty (mb_empty),
        .mb_pop   (mb_pop),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready)
    );

endmodule

// File: rtl/i2c_mbox_chk.sv
`timescale 1ns/1ps
module i2c_mbox_chk (
    input logic       clk,
    input logic       rst,
    input logic       evt_start,
    input logic       evt_stop,
    input logic       bus_busy,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic [7:0] wr_data,
    input logic       mb_load,
    input logic       mb_full,
    input logic       mb_overflow,
    input logic       irq_pull
);
    // R1
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt_start |=> bus_busy);

    // R2
    busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
        evt_stop |=> !bus_busy);

    // R2
    busy_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !evt_stop) |=> bus_busy);

    // R4
    sda_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> bus_busy);

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

    // R6
    wr_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |-> scl_oe);

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pull) |-> $past(mb_load));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (mb_load && mb_full) |=> mb_overflow);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mb_overflow |=> mb_overflow);

endmodule

bind i2c_mbox_port i2c_mbox_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_start   (evt_start),
    .evt_stop    (evt_stop),
    .bus_busy    (bus_busy),
    .sda_oe      (sda_oe),
    .scl_oe      (scl_oe),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_data     (wr_data),
    .mb_load     (mb_load),
    .mb_full     (mb_full),
    .mb_overflow (mb_overflow),
    .irq_pull    (irq_pull)
);

// File: tb/tb_i2c_mbox_port.sv
`timescale 1ns/1ps
module tb_i2c_mbox_port;

    localparam int H    = 20;
    localparam int MSGB = 2;
    localparam logic [6:0] OWN = 7'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl_low = 1'b0;
    logic        m_sda_low = 1'b0;
    logic        scl_oe;
    logic        sda_oe;
    logic        scl_line;
    logic        sda_line;
    logic        wr_valid;
    logic [7:0]  wr_data;
    logic        wr_ready;
    logic        man_rdy = 1'b1;
    logic        rand_rdy = 1'b0;
    logic        rnd_bit = 1'b1;
    logic        mb_load = 1'b0;
    logic [15:0] mb_msg = '0;
    logic        mb_full;
    logic        mb_overflow;
    logic        irq_pull;
    logic        bus_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] cap [256];
    int cap_total = 0;

    assign scl_line = ~(m_scl_low | scl_oe);
    assign sda_line = ~(m_sda_low | sda_oe);
    assign wr_ready = rand_rdy ? rnd_bit : man_rdy;

    always #10 clk = ~clk;

    i2c_mbox_port dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_line),
        .scl_oe      (scl_oe),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .own_addr    (OWN),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .mb_load     (mb_load),
        .mb_msg      (mb_msg),
        .mb_full     (mb_full),
        .mb_overflow (mb_overflow),
        .irq_pull    (irq_pull),
        .bus_busy    (bus_busy)
    );

    always @(posedge clk) begin
        if (!rst && wr_valid && wr_ready) begin
            cap[cap_total % 256] <= wr_data;
            cap_total <= cap_total + 1;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            rnd_bit = ($urandom % 3) != 0;
        end
    end

    function automatic logic [7:0] exp_byte(input logic [15:0] m, input int i);
        logic [15:0] s;
        s = m >> ((MSGB - 1 - i) * 8);
        return s[7:0];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_release();
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0;
        wait_cyc(H);
        scl_release();
        wait_cyc(H);
        m_sda_low = 1'b1;
        wait_cyc(H);
        m_scl_low = 1'b1;
        wait_cyc(H);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        wait_cyc(H);
        scl_release();
        wait_cyc(H);
        m_sda_low = 1'b0;
        wait_cyc(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = ~b;
        wait_cyc(H);
        scl_release();
        wait_cyc(H);
        m_scl_low = 1'b1;
    endtask

    task automatic recv_bit(output logic b);
        m_sda_low = 1'b0;
        wait_cyc(H);
        scl_release();
        wait_cyc(H / 2);
        b = sda_line;
        wait_cyc(H / 2);
        m_scl_low = 1'b1;
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    task automatic load_msg(input logic [15:0] m);
        mb_msg  = m;
        mb_load = 1'b1;
        @(negedge clk);
        mb_load = 1'b0;
        @(negedge clk);
    endtask

    logic [15:0] msgs [8];
    logic        ack;
    logic [7:0]  rd;
    int          base;

    initial begin
        void'($urandom(32'd7319));
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);

        // R9 R11 R1: reset state
        check(irq_pull == 0, "R9 reset irq", irq_pull, 0);
        check(bus_busy == 0, "R1 reset busy", bus_busy, 0);
        check(scl_oe == 0 && sda_oe == 0, "R4 reset drive", {scl_oe, sda_oe}, 0);
        check(mb_full == 0 && mb_overflow == 0, "R11 reset mailbox", {mb_full, mb_overflow}, 0);

        // R4: foreign address
        base = cap_total;
        bus_start();
        check(bus_busy == 1, "R1 busy after start", bus_busy, 1);
        write_byte({7'h11, 1'b0}, ack);
        check(ack == 0, "R4 mismatch no ack", ack, 0);
        write_byte(8'h00, ack);
        check(ack == 0 && cap_total == base, "R4 mismatch no data", cap_total - base, 0);
        bus_stop();
        check(bus_busy == 0, "R2 idle after stop", bus_busy, 0);

        // R3 R5: plain write
        base = cap_total;
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        check(ack == 1, "R3 address ack", ack, 1);
        write_byte(8'hA5, ack);
        write_byte(8'h3C, ack);
        bus_stop();
        check(cap_total - base == 2, "R5 byte count", cap_total - base, 2);
        check(cap[base % 256] == 8'hA5, "R5 byte0", cap[base % 256], 8'hA5);
        check(cap[(base + 1) % 256] == 8'h3C, "R5 byte1", cap[(base + 1) % 256], 8'h3C);

        // R6: core not ready stretches SCL
        base = cap_total;
        man_rdy = 1'b0;
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        fork
            write_byte(8'h96, ack);
            begin
                wait_cyc(9 * 2 * H + 150);
                check(scl_oe == 1 && scl_line == 0, "R6 stretch held", scl_oe, 1);
                check(wr_valid == 1 && wr_data == 8'h96, "R5 data offered", wr_data, 8'h96);
                man_rdy = 1'b1;
            end
        join
        check(ack == 1, "R6 ack after ready", ack, 1);
        bus_stop();
        check(cap_total - base == 1 && cap[base % 256] == 8'h96, "R6 byte delivered",
              cap[base % 256], 8'h96);

        // R12: repeated start mid-byte
        base = cap_total;
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        check(bus_busy == 1, "R2 busy across repeated start", bus_busy, 1);
        write_byte({OWN, 1'b0}, ack);
        check(ack == 1, "R12 readdressed", ack, 1);
        write_byte(8'h5A, ack);
        bus_stop();
        check(cap_total - base == 1 && cap[base % 256] == 8'h5A, "R12 partial dropped",
              cap_total - base, 1);

        // R11 R9: fill the mailbox
        msgs[0] = 16'hC3A1; msgs[1] = 16'h1234; msgs[2] = 16'hBEEF; msgs[3] = 16'h0F70;
        load_msg(msgs[0]);
        check(irq_pull == 1, "R9 irq after load", irq_pull, 1);
        load_msg(msgs[1]); load_msg(msgs[2]);
        check(mb_full == 0, "R11 not full at three", mb_full, 0);
        load_msg(msgs[3]);
        check(mb_full == 1, "R11 full at four", mb_full, 1);
        load_msg(16'hDEAD);
        check(mb_overflow == 1, "R11 overflow", mb_overflow, 1);

        // R7: whole message
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        check(ack == 1, "R3 read address ack", ack, 1);
        read_byte(1'b1, rd);
        check(rd == exp_byte(msgs[0], 0), "R7 msg0 byte0", rd, exp_byte(msgs[0], 0));
        read_byte(1'b0, rd);
        check(rd == exp_byte(msgs[0], 1), "R7 msg0 byte1", rd, exp_byte(msgs[0], 1));
        check(sda_oe == 0, "R13 released after nack", sda_oe, 0);
        bus_stop();
        check(irq_pull == 1 && mb_full == 0, "R10 one consumed", {irq_pull, mb_full}, 2'b10);

        // R10: NACK before last byte keeps message
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        read_byte(1'b0, rd);
        check(rd == exp_byte(msgs[1], 0), "R10 partial byte0", rd, exp_byte(msgs[1], 0));
        bus_stop();
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        read_byte(1'b1, rd);
        check(rd == exp_byte(msgs[1], 0), "R10 restart byte0", rd, exp_byte(msgs[1], 0));
        read_byte(1'b1, rd);
        check(rd == exp_byte(msgs[1], 1), "R10 byte1", rd, exp_byte(msgs[1], 1));
        // R7: ACK continues into the next message
        for (int i = 0; i < 4; i++) begin
            read_byte(i != 3, rd);
            check(rd == exp_byte(msgs[2 + i / 2], i % 2), "R7 run across messages",
                  rd, exp_byte(msgs[2 + i / 2], i % 2));
        end
        bus_stop();
        check(irq_pull == 0, "R9 irq released after drain", irq_pull, 0);
        check(mb_overflow == 1, "R11 overflow sticky", mb_overflow, 1);

        // R8: read from an empty mailbox stretches
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        fork
            read_byte(1'b0, rd);
            begin
                wait_cyc(300);
                check(scl_oe == 1 && scl_line == 0, "R8 stretch on empty", scl_oe, 1);
                load_msg(16'h6E81);
            end
        join
        check(rd == 8'h6E, "R8 byte after load", rd, 8'h6E);
        bus_stop();
        check(irq_pull == 1, "R10 nack mid keeps msg", irq_pull, 1);
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        read_byte(1'b1, rd);
        read_byte(1'b0, rd);
        check(rd == 8'h81, "R7 second byte", rd, 8'h81);
        bus_stop();
        check(irq_pull == 0, "R9 irq clear", irq_pull, 0);

        // random rounds
        rand_rdy = 1'b1;
        for (int r = 0; r < 16; r++) begin
            int nm;
            int nw;
            logic [7:0] wb [4];
            nm = 1 + ($urandom % 3);
            nw = 1 + ($urandom % 3);
            for (int k = 0; k < nm; k++) begin
                msgs[k] = 16'($urandom);
                load_msg(msgs[k]);
            end
            base = cap_total;
            bus_start();
            write_byte({OWN, 1'b0}, ack);
            for (int k = 0; k < nw; k++) begin
                wb[k] = 8'($urandom);
                write_byte(wb[k], ack);
            end
            bus_stop();
            for (int k = 0; k < nw; k++)
                check(cap[(base + k) % 256] == wb[k], "R5 random write",
                      cap[(base + k) % 256], wb[k]);
            bus_start();
            write_byte({OWN, 1'b1}, ack);
            for (int k = 0; k < nm * MSGB; k++) begin
                read_byte(k != nm * MSGB - 1, rd);
                check(rd == exp_byte(msgs[k / MSGB], k % MSGB), "R7 random read",
                      rd, exp_byte(msgs[k / MSGB], k % MSGB));
            end
            bus_stop();
            check(irq_pull == 0, "R9 random drain", irq_pull, 0);
        end
        rand_rdy = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule